// File: doc/BRIEF.md
# Conversion Result Register Pair with Alignment and Read Lock

This block keeps the most recent 10-bit conversion result and presents it to a host as two 8-bit bytes: a low byte at address 0 and a high byte at address 1. A control input chooses how the 10 bits sit inside the 16-bit pair. In right alignment the full value reads as an ordinary number. In left alignment the eight most significant bits fill the high byte, so a host that needs only 8 bits of precision can read that one byte.

A host that wants all ten bits reads the low byte first and the high byte second. A low-byte read locks the pair. While the pair is locked, completed conversions are dropped, so both bytes of a two-byte read come from the same conversion. The high-byte read removes the lock. The read port is combinational: the byte selected by the address appears on the data output in the same cycle. The read strobe only drives the lock.

Top module: `adc_result_regs`

## Requirements
- R1: With `align_left_i` low, the low byte holds result bits 7:0. The high byte holds result bits 9:8 in its bits 1:0, and its bits 7:2 read zero.
- R2: With `align_left_i` high, the high byte holds result bits 9:2. The low byte holds result bits 1:0 in its bits 7:6, and its bits 5:0 read zero.
- R3: `rd_addr_i` = 0 selects the low byte and 1 selects the high byte. `rd_data_o` shows the selected byte in the same cycle, whether or not `rd_en_i` is high.
- R4: A cycle with `rd_en_i` high and `rd_addr_i` = 0 locks the pair. A conversion in that same cycle is discarded, and so is every conversion while the pair is locked.
- R5: A cycle with `rd_en_i` high and `rd_addr_i` = 1 releases the lock at the next clock edge. A conversion that arrives in that same cycle is still discarded. Conversions after the release update the pair.
- R6: While unlocked, a cycle with `conv_valid_i` high stores `conv_data_i`, and the new value is readable from the next cycle.
- R7: A change of `align_left_i` reformats the stored value on the very next read, without a new conversion.
- R8: During reset and after it, both bytes read zero and the pair is unlocked. The first conversion after reset is stored.
- R9: A high-byte read without a prior low-byte read does not lock the pair. Repeated high-byte-only reads keep seeing each new conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| conv_valid_i | input | 1 | A completed conversion is on `conv_data_i` this cycle |
| conv_data_i | input | 10 | Conversion value |
| align_left_i | input | 1 | 1 = left aligned, 0 = right aligned |
| rd_en_i | input | 1 | Host read strobe for the byte at `rd_addr_i` |
| rd_addr_i | input | 1 | Byte address: 0 = low, 1 = high |
| rd_data_o | output | 8 | Selected byte |

## Verification
Directed sequences cover the following cases:
- A low-then-high read with conversions arriving in between. This separates a correct lock from one that is missing or released too early.
- A conversion that lands in the same cycle as a low-byte read, and one that lands in the same cycle as a high-byte read. These check the edges of the lock window.
- High-byte-only reads. These catch a lock set by the wrong address.
- Alignment toggles with no new conversion. These show whether formatting is applied on output or frozen at capture.

Seeded random traffic then mixes conversions, reads at both addresses and alignment changes. Every read is compared with a bench model of the stored value and the lock state.

// File: rtl/adc_res_pkg.sv
package adc_res_pkg;
  typedef enum logic {
    BYTE_LO = 1'b0,
    BYTE_HI = 1'b1
  } byte_sel_e;
endpackage

// File: rtl/adc_res_rstsync.sv
module adc_res_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_d, sync_q;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/adc_res_lock.sv
module adc_res_lock
  import adc_res_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      rd_en_i,
  input  byte_sel_e rd_sel_i,
  input  logic      conv_valid_i,
  output logic      locked_o,
  output logic      accept_o
);
  logic lock_d, lock_q;
  logic rd_lo, rd_hi;

  always_comb begin
    rd_lo  = rd_en_i && (rd_sel_i == BYTE_LO);
    rd_hi  = rd_en_i && (rd_sel_i == BYTE_HI);
    lock_d = lock_q;
    if (rd_lo)      lock_d = 1'b1;
    else if (rd_hi) lock_d = 1'b0;
    accept_o = conv_valid_i && !lock_q && !rd_lo;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lock_q <= 1'b0;
    else         lock_q <= lock_d;
  end

  assign locked_o = lock_q;

  // R4: a low-byte read leaves the pair locked
  assert_lock_on_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_sel_i == BYTE_LO) |=> locked_o);
  // R5: a high-byte read leaves the pair unlocked
  assert_unlock_on_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_sel_i == BYTE_HI) |=> !locked_o);
  // R9: without any read strobe the lock state holds
  assert_lock_steady_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(locked_o));
endmodule

// File: rtl/adc_res_store.sv
module adc_res_store #(
  parameter int RES_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic [RES_W-1:0] data_i,
  output logic [RES_W-1:0] res_o
);
  logic [RES_W-1:0] res_d, res_q;
  logic             res_en;

  always_comb begin
    res_en = accept_i;
    res_d  = data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     res_q <= '0;
    else if (res_en) res_q <= res_d;
  end

  assign res_o = res_q;
endmodule

// File: rtl/adc_res_align.sv
module adc_res_align
  import adc_res_pkg::*;
#(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input  logic [RES_W-1:0]  res_i,
  input  logic              left_i,
  input  byte_sel_e         sel_i,
  output logic [BYTE_W-1:0] byte_o
);
  localparam int PAIR_W = 2 * BYTE_W;
  localparam int PAD_W  = PAIR_W - RES_W;

  logic [PAIR_W-1:0] pair;

  always_comb begin
    pair = PAIR_W'(res_i);
    if (left_i) pair = pair << PAD_W;
    if (sel_i == BYTE_HI) byte_o = pair[PAIR_W-1:BYTE_W];
    else                  byte_o = pair[BYTE_W-1:0];
  end
endmodule

// File: rtl/adc_result_regs.sv
module adc_result_regs
  import adc_res_pkg::*;
#(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              conv_valid_i,
  input  logic [RES_W-1:0]  conv_data_i,
  input  logic              align_left_i,
  input  logic              rd_en_i,
  input  logic              rd_addr_i,
  output logic [BYTE_W-1:0] rd_data_o
);
  localparam int HI_USED = RES_W - BYTE_W;
  localparam int PAD_W   = 2 * BYTE_W - RES_W;

  logic             rst_sync_n;
  logic             locked, accept;
  logic [RES_W-1:0] res_q;
  byte_sel_e        rd_sel;

  assign rd_sel = byte_sel_e'(rd_addr_i);

  adc_res_rstsync #(.STAGES(2)) u_rstsync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_sync_no(rst_sync_n)
  );

  adc_res_lock u_lock (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .rd_en_i     (rd_en_i),
    .rd_sel_i    (rd_sel),
    .conv_valid_i(conv_valid_i),
    .locked_o    (locked),
    .accept_o    (accept)
  );

  adc_res_store #(.RES_W(RES_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .accept_i(accept),
    .data_i  (conv_data_i),
    .res_o   (res_q)
  );

  adc_res_align #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_align (
    .res_i (res_q),
    .left_i(align_left_i),
    .sel_i (rd_sel),
    .byte_o(rd_data_o)
  );

  // R4: stored value is frozen while the pair is locked
  assert_hold_locked_R4: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    locked |=> $stable(res_q));
  // R6: an unlocked conversion without a low-byte read is stored
  assert_capture_R6: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (conv_valid_i && !locked && !(rd_en_i && !rd_addr_i)) |=> (res_q == $past(conv_data_i)));
  // R1: right aligned high byte has zero in its unused upper bits
  assert_right_pad_R1: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (!align_left_i && rd_addr_i) |-> ((rd_data_o >> HI_USED) == '0));
  // R2: left aligned low byte has zero in its unused lower bits
  assert_left_pad_R2: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (align_left_i && !rd_addr_i) |-> ((rd_data_o & BYTE_W'((1 << PAD_W) - 1)) == '0));
endmodule

// File: tb/adc_result_regs_tb_top.sv
`timescale 1ns/1ps
module adc_result_regs_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       conv_valid_i;
  logic [9:0] conv_data_i;
  logic       align_left_i;
  logic       rd_en_i;
  logic       rd_addr_i;
  logic [7:0] rd_data_o;

  int n_checks = 0;
  int n_fail   = 0;
  logic [9:0] exp_res;
  bit         exp_lock;

  always #2.5 clk_i = ~clk_i;

  adc_result_regs dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .conv_valid_i(conv_valid_i),
    .conv_data_i (conv_data_i),
    .align_left_i(align_left_i),
    .rd_en_i     (rd_en_i),
    .rd_addr_i   (rd_addr_i),
    .rd_data_o   (rd_data_o)
  );

  function automatic logic [7:0] fmt(input logic [9:0] r, input bit left, input bit hi);
    logic [15:0] p;
    p = left ? {r, 6'b000000} : {6'b000000, r};
    return hi ? p[15:8] : p[7:0];
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: rd_data_o=%02h expected=%02h", req, act, exp);
    end
  endtask

  // One bus cycle: drive at negedge, check the read, update the model at posedge.
  task automatic step(input string req, input bit cv, input logic [9:0] d,
                      input bit left, input bit re, input bit addr);
    @(negedge clk_i);
    conv_valid_i = cv; conv_data_i = d; align_left_i = left;
    rd_en_i = re; rd_addr_i = addr;
    #1;
    check(req, rd_data_o, fmt(exp_res, left, addr));
    @(posedge clk_i);
    if (cv && !exp_lock && !(re && !addr)) exp_res = d;
    if (re && !addr)     exp_lock = 1'b1;
    else if (re && addr) exp_lock = 1'b0;
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_checks++; n_fail++;
    $display("FAIL watchdog: run did not complete, expected end before timeout");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_ni = 1'b0; conv_valid_i = 1'b0; conv_data_i = '0; align_left_i = 1'b0;
    rd_en_i = 1'b0; rd_addr_i = 1'b0;
    exp_res = '0; exp_lock = 1'b0;
    repeat (3) @(posedge clk_i);
    // R8: both bytes zero in reset, and a conversion is ignored while held
    @(negedge clk_i); conv_valid_i = 1'b1; conv_data_i = 10'h3FF; rd_addr_i = 1'b0; #1;
    check("R8", rd_data_o, 8'h00);
    rd_addr_i = 1'b1; #1;
    check("R8", rd_data_o, 8'h00);
    conv_valid_i = 1'b0;
    rst_ni = 1'b1;
    repeat (4) @(posedge clk_i);
    step("R8", 0, 10'h000, 0, 0, 0);
    step("R8", 0, 10'h000, 0, 0, 1);
    // R8/R6: first conversion after reset is stored (pair starts unlocked)
    step("R6", 1, 10'h2B5, 0, 0, 0);
    step("R1", 0, 10'h000, 0, 0, 0);
    step("R1", 0, 10'h000, 0, 0, 1);
    // R2 and R7: same value reformatted by flipping alignment only
    step("R7", 0, 10'h000, 1, 0, 1);
    step("R2", 0, 10'h000, 1, 0, 0);
    step("R7", 0, 10'h000, 0, 0, 0);
    // R3: data shown without strobe, address picks the byte
    step("R3", 0, 10'h000, 0, 0, 1);
    // R4: low read locks; same-cycle conversion and later ones dropped
    step("R4", 1, 10'h111, 0, 1, 0);
    step("R4", 1, 10'h222, 0, 0, 0);
    step("R4", 1, 10'h0F0, 1, 0, 1);
    // R5: conversion with the releasing high read is dropped
    step("R5", 1, 10'h333, 0, 1, 1);
    step("R5", 0, 10'h000, 0, 0, 0);
    step("R5", 1, 10'h1C7, 0, 0, 0);
    step("R5", 0, 10'h000, 0, 0, 0);
    step("R5", 0, 10'h000, 0, 0, 1);
    // R9: left aligned high-only reads track each conversion
    for (int i = 0; i < 6; i++) begin
      step("R9", 0, 10'h000, 1, 1, 1);
      step("R9", 1, 10'(37 * i + 5), 1, 1, 1);
    end
    step("R9", 0, 10'h000, 1, 1, 1);
    // Random mix, requirement tagged by the mode in force
    for (int i = 0; i < 3000; i++) begin
      bit cv, re, ad, lf;
      cv = ($urandom % 2) == 0;
      re = ($urandom % 5) < 2;
      ad = ($urandom % 2) == 1;
      lf = ($urandom % 8) == 0 ? ~align_left_i : align_left_i;
      step(exp_lock ? "R4" : (lf ? "R2" : "R1"), cv, 10'($urandom), lf, re, ad);
    end
    finish_run();
  end
endmodule